// File: doc/BRIEF.md
# Indirect-Indexed Bank Select Sequencer

This block picks which of two 4-bit bank registers drives the upper address outputs of a bank-switched processor. Register 0 is the default source. When the instruction just fetched is one of the two accumulator load/store opcodes that use indirect addressing indexed by Y, the block switches the outputs to register 1, but only for that instruction's operand data cycles. The pointer and base-address fetches that come first still use register 0.

One clock period is one processor bus cycle. The block takes an early fetch strobe, which is high in the cycle before an opcode fetch, together with the fetched byte, a forced-break indicator, the ready line, the write flag and both register values. A match launches a delay line of three stages. The delay line holds during read wait cycles. When it expires it sets a select flag, and the next early fetch strobe clears that flag. The selected bank value is registered before it reaches the outputs.

Top module: `ixbank_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `bank_addr` is loaded with all ones. The select flag and the delay stages are cleared.
- R2: The fetch cycle is the cycle after `sync_early` was high. When the byte sampled in a ready fetch cycle is 0xB1 or 0x91 (they differ only in bit 5), `bank_addr` shows `bank1` from the fourth advancing cycle after the fetch (T4) onward.
- R3: For any other fetched byte, `bank_addr` shows `bank0` in every cycle of the instruction.
- R4: A matching byte fetched while `brk_forced` is high causes no switch.
- R5: In the three advancing cycles that follow a matching fetch (T1 to T3), `bank_addr` shows `bank0`.
- R6: Once set, the selection stays in place through T5 and later cycles. It ends after the cycle in which `sync_early` is high, so the next fetch cycle shows `bank0`. A clear wins over a set in the same cycle.
- R7: A read wait cycle (`rdy` low, `wr` low) does not advance the delay line, so the switch comes one cycle later for each such cycle.
- R8: A cycle with `rdy` low and `wr` high is a write, and it advances the delay line like a ready cycle.
- R9: A fetch cycle with `rdy` low is repeated. Detection uses the byte of the ready repetition.
- R10: `bank_addr` is registered: in each cycle it shows the bank value that was present on the inputs in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| sync_early | input | 1 | High in the cycle before an opcode fetch |
| data_in | input | 8 | Data byte of the current bus cycle |
| brk_forced | input | 1 | Fetch replaced by a forced break |
| rdy | input | 1 | Ready; low stalls read cycles |
| wr | input | 1 | Write flag of the current cycle |
| bank0 | input | 4 | Bank register 0 value |
| bank1 | input | 4 | Bank register 1 value |
| bank_addr | output | 4 | Registered bank address outputs |

## Verification
The bench builds the block with its defaults: a 4-bit bank width and a delay line three stages deep. At that size every one of the 256 opcode values can be swept, both with and without a forced break, with each cycle of T0 to T5 compared against an arithmetic model. Read stalls and write stalls are placed at every position from T1 to T5, and fetch-cycle stalls and early terminations at T3 and T4 are also run. This covers every moment at which a stall or a clear can meet the set event.

// File: rtl/ixbank_pkg.sv
package ixbank_pkg;
  typedef enum logic {
    SRC_LOW  = 1'b0,
    SRC_HIGH = 1'b1
  } bank_src_e;
endpackage

// File: rtl/ixbank_opdec.sv
module ixbank_opdec #(
  parameter int          DW    = 8,
  parameter logic [7:0]  OPC_A = 8'hB1,
  parameter logic [7:0]  OPC_B = 8'h91
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_early,
  input  logic [DW-1:0] data_in,
  input  logic          brk_forced,
  input  logic          adv,
  output logic          fetch_q,
  output logic          hit
);
  // bits where the two opcodes differ are don't-care in the compare
  localparam logic [DW-1:0] CARE = ~(DW'(OPC_A) ^ DW'(OPC_B));
  localparam logic [DW-1:0] REF  = DW'(OPC_A) & CARE;

  logic match;

  assign match = ((data_in & CARE) == REF);
  assign hit   = fetch_q & adv & ~brk_forced & match;

  // fetch cycle marker; a stalled fetch repeats
  always_ff @(posedge clk) begin
    if (rst) fetch_q <= 1'b0;
    else     fetch_q <= sync_early | (fetch_q & ~adv);
  end

  a_r9_fetch_held: assert property (@(posedge clk) disable iff (rst)
    (fetch_q && !adv) |=> fetch_q);
endmodule

// File: rtl/ixbank_delay.sv
module ixbank_delay #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_q,
  input  logic             adv,
  input  logic             hit,
  output logic [DEPTH-1:0] stages,
  output logic             tap
);
  logic [DEPTH-1:0] nxt;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_comb begin
          if (fetch_q)  nxt[i] = hit;
          else if (adv) nxt[i] = 1'b0;
          else          nxt[i] = stages[i];
        end
      end else begin : g_body
        always_comb begin
          if (fetch_q)  nxt[i] = 1'b0;
          else if (adv) nxt[i] = stages[i-1];
          else          nxt[i] = stages[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= nxt;
  end

  assign tap = stages[DEPTH-1];

  a_r2_single_token: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stages));
  a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (!adv && !fetch_q) |=> $stable(stages));
endmodule

// File: rtl/ixbank_outsel.sv
module ixbank_outsel
  import ixbank_pkg::*;
#(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_early,
  input  logic          tap,
  input  logic          adv,
  input  logic          fetch_q,
  input  logic [BW-1:0] bank0,
  input  logic [BW-1:0] bank1,
  output logic          sel_q,
  output logic [BW-1:0] bank_addr
);
  bank_src_e src_n;
  logic      set_ev;

  assign set_ev = tap & adv & ~fetch_q;

  // clear has priority over set
  always_comb begin
    if (sync_early)  src_n = SRC_LOW;
    else if (set_ev) src_n = SRC_HIGH;
    else             src_n = bank_src_e'(sel_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      bank_addr <= '1;
    end else begin
      sel_q     <= src_n;
      bank_addr <= (src_n == SRC_HIGH) ? bank1 : bank0;
    end
  end

  a_r6_clear_on_fetch: assert property (@(posedge clk) disable iff (rst)
    sync_early |=> !sel_q);
endmodule

// File: rtl/ixbank_seq.sv
module ixbank_seq #(
  parameter int BW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_early,
  input  logic [DW-1:0] data_in,
  input  logic          brk_forced,
  input  logic          rdy,
  input  logic          wr,
  input  logic [BW-1:0] bank0,
  input  logic [BW-1:0] bank1,
  output logic [BW-1:0] bank_addr
);
  logic             adv;
  logic             fetch_q;
  logic             hit;
  logic [DEPTH-1:0] stages;
  logic             tap;
  logic             sel_q;

  // only reads wait on ready
  assign adv = rdy | wr;

  ixbank_opdec #(.DW(DW)) u_dec (
    .clk(clk), .rst(rst), .sync_early(sync_early), .data_in(data_in),
    .brk_forced(brk_forced), .adv(adv), .fetch_q(fetch_q), .hit(hit)
  );

  ixbank_delay #(.DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst(rst), .fetch_q(fetch_q), .adv(adv), .hit(hit),
    .stages(stages), .tap(tap)
  );

  ixbank_outsel #(.BW(BW)) u_out (
    .clk(clk), .rst(rst), .sync_early(sync_early), .tap(tap), .adv(adv),
    .fetch_q(fetch_q), .bank0(bank0), .bank1(bank1), .sel_q(sel_q),
    .bank_addr(bank_addr)
  );

  a_r4_break_blocks: assert property (@(posedge clk) disable iff (rst)
    (fetch_q && brk_forced) |=> (stages == '0));
  a_r10_loads_bank1: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_q) |-> (bank_addr == $past(bank1)));
endmodule

// File: tb/test_ixbank_seq.sv
module test_ixbank_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       sync_early;
  logic [7:0] data_in;
  logic       brk_forced;
  logic       rdy;
  logic       wr;
  logic [3:0] bank0;
  logic [3:0] bank1;
  logic [3:0] bank_addr;

  int checks   = 0;
  int failures = 0;
  logic [3:0] prev_b0;

  always #5 clk = ~clk;

  ixbank_seq i_ixbank_seq (
    .clk(clk), .rst(rst), .sync_early(sync_early), .data_in(data_in),
    .brk_forced(brk_forced), .rdy(rdy), .wr(wr), .bank0(bank0),
    .bank1(bank1), .bank_addr(bank_addr)
  );

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (bank_addr !== exp) begin
      failures++;
      $display("FAIL %s: bank_addr=%h expected=%h", req, bank_addr, exp);
    end
  endtask

  // one bus cycle: drive inputs just after the edge, check the output of this cycle
  task automatic cyc(input logic se, input logic [7:0] d, input logic brk,
                     input logic r, input logic w, input logic [3:0] b0,
                     input logic [3:0] b1, input logic [3:0] exp, input string req);
    @(posedge clk);
    #1;
    sync_early = se; data_in = d; brk_forced = brk; rdy = r; wr = w;
    bank0 = b0; bank1 = b1;
    check(exp, req);
  endtask

  // one instruction starting at its fetch cycle; the last cycle raises sync_early
  task automatic insn(input logic [7:0] op, input logic brk, input logic fstall,
                      input int stall_pos, input logic stall_wr, input int len,
                      input logic [3:0] b0, input logic [3:0] b1, input string req);
    logic hit;
    int adv;
    hit = (((op | 8'h20) == 8'hB1) && !brk);
    adv = 0;
    if (fstall) begin
      cyc(1'b0, 8'hB1, brk, 1'b0, 1'b0, b0, b1, prev_b0, "R9");
      cyc(1'b0, op, brk, 1'b1, 1'b0, b0, b1, b0, "R9");
    end else begin
      cyc(1'b0, op, brk, 1'b1, 1'b0, b0, b1, prev_b0, "R10");
    end
    for (int i = 1; i <= len; i++) begin
      if (i == stall_pos) begin
        cyc(1'b0, 8'hB1, 1'b0, 1'b0, stall_wr, b0, b1,
            (hit && adv >= 3) ? b1 : b0, stall_wr ? "R8" : "R7");
        if (stall_wr) adv++;
      end
      cyc(i == len, 8'h00, 1'b0, 1'b1, 1'b0, b0, b1,
          (hit && adv >= 3) ? b1 : b0, (hit && adv < 3) ? "R5" : req);
      adv++;
    end
    prev_b0 = b0;
  endtask

  initial begin : watchdog
    #2000000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; sync_early = 1'b0; data_in = 8'h00; brk_forced = 1'b0;
    rdy = 1'b1; wr = 1'b0; bank0 = 4'h5; bank1 = 4'hA;
    @(posedge clk); @(posedge clk);
    #1;
    check(4'hF, "R1");
    // first cycle out of reset announces a fetch
    @(posedge clk);
    #1;
    rst = 1'b0; sync_early = 1'b1;
    check(4'hF, "R1");
    prev_b0 = 4'h5;

    // R2/R3: every opcode, T0..T5
    for (int op = 0; op < 256; op++) begin
      insn(8'(op), 1'b0, 1'b0, 0, 1'b0, 5, op[3:0], ~op[3:0],
           (((op | 32) == 8'hB1)) ? "R2" : "R3");
    end
    // R4: forced break on every opcode
    for (int op = 0; op < 256; op++) begin
      insn(8'(op), 1'b1, 1'b0, 0, 1'b0, 5, op[7:4], ~op[7:4], "R4");
    end
    // R7/R8: read and write stalls at each position
    for (int p = 1; p <= 5; p++) begin
      insn(8'hB1, 1'b0, 1'b0, p, 1'b0, 5, 4'h3, 4'hC, "R7");
      insn(8'h91, 1'b0, 1'b0, p, 1'b1, 5, 4'h6, 4'h9, "R8");
      insn(8'hA1, 1'b0, 1'b0, p, 1'b0, 5, 4'h2, 4'hD, "R3");
    end
    // R9: stalled fetch cycle
    insn(8'hB1, 1'b0, 1'b1, 0, 1'b0, 5, 4'h1, 4'hE, "R9");
    insn(8'h00, 1'b0, 1'b1, 0, 1'b0, 5, 4'h7, 4'h8, "R9");
    // R6: clear at T3 beats the set, clear after T4, long hold
    insn(8'h91, 1'b0, 1'b0, 0, 1'b0, 3, 4'h4, 4'hB, "R6");
    insn(8'hB1, 1'b0, 1'b0, 0, 1'b0, 4, 4'h0, 4'hF, "R6");
    insn(8'hB1, 1'b0, 1'b0, 0, 1'b0, 8, 4'h5, 4'hA, "R6");
    insn(8'h20, 1'b0, 1'b0, 0, 1'b0, 5, 4'h5, 4'hA, "R6");
    // R10: bank1 change while selected shows up one cycle later
    insn(8'hB1, 1'b0, 1'b0, 0, 1'b0, 4, 4'h5, 4'hA, "R10");
    cyc(1'b0, 8'hB1, 1'b0, 1'b1, 1'b0, 4'h5, 4'hA, 4'h5, "R10");
    for (int i = 1; i <= 3; i++)
      cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'h5, 4'hA, 4'h5, "R5");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'h5, 4'h3, 4'hA, "R10");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'h5, 4'h3, 4'h3, "R10");
    // R1: reset while bank1 is selected
    @(posedge clk);
    #1;
    rst = 1'b1;
    check(4'h3, "R10");
    @(posedge clk);
    #1;
    check(4'hF, "R1");
    rst = 1'b0; sync_early = 1'b1;
    prev_b0 = 4'h5;
    insn(8'h10, 1'b0, 1'b0, 0, 1'b0, 5, 4'h5, 4'hA, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule